// File: doc/BRIEF.md
# Bit-Serial Adder with Sequencer

This block forms the sum of two unsigned operands one bit per clock, using a single full adder and one carry register. Each operand sits in its own right-shifting register. During an addition the sum bit produced from the two low bits re-enters the first register at its top, so that register ends up holding the sum. The low bit of the second register is fed back into its own top, so after a full pass it is back where it began.

A small sequencer waits in an idle state until `start` is seen. It then clears the carry and its step counter and runs exactly `WIDTH` shift steps, one per cycle. After the last step it raises `done` for one cycle and returns to idle. Operands are loaded in parallel only while idle, and both registers can be read at any time. The carry left by the most significant bit appears on `carry_out` and stays there until the next addition starts.

Top module: `serial_adder_top`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), `a_out`, `b_out`, `busy`, `done` and `carry_out` are all 0.
- R2: In idle, `load_a` (or `load_b`) high at a clock edge copies `din_a` (or `din_b`) into the register, visible on `a_out` (or `b_out`) after that edge.
- R3: A `start` seen in idle makes `busy` high for exactly `WIDTH` (8) consecutive cycles, then `done` high for exactly one cycle, then both low (idle).
- R4: While `done` is high, `a_out` equals (A + B) mod 2^WIDTH of the operands held when `start` was seen.
- R5: While `done` is high, `b_out` equals the B operand held when `start` was seen.
- R6: While `done` is high, `carry_out` equals bit WIDTH of A + B.
- R7: `start` while `busy` or `done` is high has no effect: the sequence length and the result do not change.
- R8: `load_a` and `load_b` while `busy` or `done` is high are ignored: registers keep the addition's values.
- R9: The carry is cleared when an addition starts, so a carry of 1 from a previous addition does not enter the next sum; `carry_out` is 0 in the first busy cycle.
- R10: Operands are processed least significant bit first; in every busy step `b_out` rotates right by one bit (old bit 0 becomes the new top bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an addition (honoured in idle only) |
| load_a | input | 1 | Parallel load of operand A (idle only) |
| load_b | input | 1 | Parallel load of operand B (idle only) |
| din_a | input | WIDTH | Parallel data for A |
| din_b | input | WIDTH | Parallel data for B |
| a_out | output | WIDTH | Contents of register A (sum after an addition) |
| b_out | output | WIDTH | Contents of register B |
| busy | output | 1 | High during the shift steps |
| done | output | 1 | One-cycle completion pulse |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
A stuck or mis-cleared carry flop corrupts the sum from the first bit it touches and shows as a wrong `a_out` or `carry_out` at the `done` pulse, eight cycles after start; a leftover carry from a prior addition shows as an odd sum on the next one. A step counter that is off by one changes the length of `busy` and leaves both registers rotated, so `b_out` differs from the loaded operand at `done`. A broken recirculation path in B shows on the very next busy cycle, since `b_out` must rotate right each step.

// File: rtl/serial_add_pkg.sv
package serial_add_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/sa_full_adder.sv
module sa_full_adder (
    input  logic in_x,
    input  logic in_y,
    input  logic in_c,
    output logic sum,
    output logic cout
);

    always_comb begin
        sum  = in_x ^ in_y ^ in_c;
        cout = (in_x & in_y) | (in_x & in_c) | (in_y & in_c);
    end

endmodule

// File: rtl/sa_bit_reg.sv
// Right-shifting operand register with a two-way input multiplexer:
// sel = 1 takes the parallel word, sel = 0 shifts in ser_in at the top.
module sa_bit_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             sel,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q
);

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (sel) begin
                st_d.word = par_in;
            end else begin
                st_d.word = {ser_in, st_q.word[WIDTH-1:1]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.word;

endmodule

// File: rtl/sa_seq_ctrl.sv
module sa_seq_ctrl
    import serial_add_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic load_a,
    input  logic load_b,
    output logic en_a,
    output logic sel_a,
    output logic en_b,
    output logic sel_b,
    output logic clr_carry,
    output logic step,
    output logic fin
);

    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic is_idle;
    logic is_run;

    always_comb begin
        is_idle = (st_q.state == SEQ_IDLE);
        is_run  = (st_q.state == SEQ_RUN);
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            SEQ_IDLE: begin
                if (start) begin
                    st_d.state = SEQ_RUN;
                    st_d.cnt   = '0;
                end
            end
            SEQ_RUN: begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == LAST_STEP) begin
                    st_d.state = SEQ_DONE;
                end
            end
            SEQ_DONE: begin
                st_d.state = SEQ_IDLE;
            end
            default: begin
                st_d.state = SEQ_IDLE;
                st_d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.state <= SEQ_IDLE;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        sel_a     = is_idle;
        sel_b     = is_idle;
        en_a      = is_run | (is_idle & load_a);
        en_b      = is_run | (is_idle & load_b);
        clr_carry = is_idle & start;
        step      = is_run;
        fin       = (st_q.state == SEQ_DONE);
    end

endmodule

// File: rtl/serial_adder_top.sv
module serial_adder_top #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             load_a,
    input  logic             load_b,
    input  logic [WIDTH-1:0] din_a,
    input  logic [WIDTH-1:0] din_b,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] b_out,
    output logic             busy,
    output logic             done,
    output logic             carry_out
);

    typedef struct packed {
        logic carry;
    } dp_state_t;

    dp_state_t st_d, st_q;

    logic en_a, sel_a, en_b, sel_b, clr_carry, step, fin;
    logic [WIDTH-1:0] a_q, b_q;
    logic fa_sum, fa_cout;

    sa_seq_ctrl #(.WIDTH(WIDTH)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .load_a    (load_a),
        .load_b    (load_b),
        .en_a      (en_a),
        .sel_a     (sel_a),
        .en_b      (en_b),
        .sel_b     (sel_b),
        .clr_carry (clr_carry),
        .step      (step),
        .fin       (fin)
    );

    sa_full_adder fa_i (
        .in_x (a_q[0]),
        .in_y (b_q[0]),
        .in_c (st_q.carry),
        .sum  (fa_sum),
        .cout (fa_cout)
    );

    // A takes the sum bit; B recirculates its own low bit.
    sa_bit_reg #(.WIDTH(WIDTH)) reg_a_i (
        .clk    (clk),
        .rst    (rst),
        .en     (en_a),
        .sel    (sel_a),
        .par_in (din_a),
        .ser_in (fa_sum),
        .q      (a_q)
    );

    sa_bit_reg #(.WIDTH(WIDTH)) reg_b_i (
        .clk    (clk),
        .rst    (rst),
        .en     (en_b),
        .sel    (sel_b),
        .par_in (din_b),
        .ser_in (b_q[0]),
        .q      (b_q)
    );

    always_comb begin
        st_d = st_q;
        if (clr_carry) begin
            st_d.carry = 1'b0;
        end else if (step) begin
            st_d.carry = fa_cout;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_out     = a_q;
    assign b_out     = b_q;
    assign busy      = step;
    assign done      = fin;
    assign carry_out = st_q.carry;

endmodule

// File: rtl/serial_adder_chk.sv
module serial_adder_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] a_out,
    input logic [WIDTH-1:0] b_out,
    input logic             carry_out
);

    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_done_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    assert_busy_to_done_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    assert_b_rotates_R10: assert property (@(posedge clk) disable iff (rst)
        busy |=> (b_out == {$past(b_out[0]), $past(b_out[WIDTH-1:1])}));

    assert_carry_cleared_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !carry_out);

    assert_hold_after_done_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> ($stable(a_out) && $stable(b_out) && $stable(carry_out)));

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

endmodule

bind serial_adder_top serial_adder_chk #(.WIDTH(WIDTH)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .a_out     (a_out),
    .b_out     (b_out),
    .carry_out (carry_out)
);

// File: tb/serial_adder_tb.sv
module serial_adder_top_tb_top;

    localparam int W = 8;

    typedef struct {
        logic [W-1:0] sum;
        logic [W-1:0] b;
        logic         c;
    } exp_t;

    logic clk = 1'b0;
    logic rst, start, load_a, load_b;
    logic [W-1:0] din_a, din_b;
    logic [W-1:0] a_out, b_out;
    logic busy, done, carry_out;

    int n_tests = 0;
    int n_fail  = 0;
    int busy_run = 0;
    exp_t exp_q[$];
    logic [W-1:0] lfsr = 8'hA5;

    always #5 clk = ~clk;

    serial_adder_top #(.WIDTH(W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .load_a(load_a), .load_b(load_b),
        .din_a(din_a), .din_b(din_b), .a_out(a_out), .b_out(b_out),
        .busy(busy), .done(done), .carry_out(carry_out)
    );

    task automatic check(input logic ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Monitor: counts busy cycles and compares results at each done pulse.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && busy) busy_run++;
            if (!rst && done) begin
                exp_t e;
                check(busy_run == W, "R3 busy length", busy_run, W);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected done", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(a_out == e.sum, "R4 sum", a_out, e.sum);
                    check(b_out == e.b, "R5 B restored", b_out, e.b);
                    check(carry_out == e.c, "R6 carry out", carry_out, e.c);
                end
                busy_run = 0;
            end
        end
    end

    // Driver: load, start, push expected, optionally disturb, wait for done.
    task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic poke_start, input logic poke_load);
        logic [W:0] full;
        exp_t e;
        int guard;
        @(negedge clk);
        load_a = 1'b1; load_b = 1'b1; din_a = a; din_b = b;
        @(negedge clk);
        load_a = 1'b0; load_b = 1'b0;
        check(a_out == a, "R2 load A", a_out, a);
        check(b_out == b, "R2 load B", b_out, b);
        full  = {1'b0, a} + {1'b0, b};
        e.sum = full[W-1:0];
        e.b   = b;
        e.c   = full[W];
        exp_q.push_back(e);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R3 busy after start", busy, 1);
        check(carry_out == 1'b0, "R9 carry cleared", carry_out, 0);
        guard = 0;
        while (!done && guard < 50) begin
            // R7 / R8 disturbance while busy
            start  = poke_start;
            load_a = poke_load; load_b = poke_load;
            din_a  = ~a; din_b = a ^ b ^ 8'h3C;
            @(negedge clk);
            guard++;
        end
        // still in the done cycle: poke again (R7/R8)
        start = poke_start; load_a = poke_load; load_b = poke_load;
        @(negedge clk);
        start = 1'b0; load_a = 1'b0; load_b = 1'b0;
        #1;
        check(!busy && !done, "R3/R7 idle after done", {busy, done}, 0);
        check(a_out == e.sum, "R8 A held after done", a_out, e.sum);
        check(b_out == e.b, "R8 B held after done", b_out, e.b);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; load_a = 1'b0; load_b = 1'b0;
        din_a = '0; din_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(a_out == 0 && b_out == 0, "R1 regs reset", {a_out, b_out}, 0);
        check(!busy && !done && !carry_out, "R1 flags reset", {busy, done, carry_out}, 0);

        run_add(8'h03, 8'h05, 1'b0, 1'b0);
        run_add(8'hFF, 8'h01, 1'b0, 1'b0);   // carry out 1
        run_add(8'h00, 8'h00, 1'b0, 1'b0);   // R9: no leftover carry
        run_add(8'hFF, 8'hFF, 1'b1, 1'b0);   // R7 start pokes
        run_add(8'h80, 8'h80, 1'b0, 1'b1);   // R8 load pokes
        run_add(8'hAA, 8'h55, 1'b1, 1'b1);
        run_add(8'h01, 8'h80, 1'b0, 1'b0);   // R10 single bits at both ends
        for (int i = 0; i < 8; i++) begin
            logic [W-1:0] x, y;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            x = lfsr;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            y = lfsr;
            run_add(x, y, i[0], i[1]);
        end

        // R8: load in idle still works after runs; load of A alone leaves B
        @(negedge clk);
        load_a = 1'b1; din_a = 8'h5A; din_b = 8'hC3;
        @(negedge clk);
        load_a = 1'b0;
        check(a_out == 8'h5A, "R2 load A only", a_out, 8'h5A);
        check(b_out != 8'hC3, "R2 B untouched without load_b", b_out, 0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R3 all results seen", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule